// File: doc/BRIEF.md
# ADC Sample Capture Interface

This block sits between the parallel output bus of a pipelined analog-to-digital converter and an on-chip sample consumer. The converter runs its sample clock at half its input clock, and each output word comes with an out-of-range bit and a data-valid strobe one converter clock wide. A word leaves the converter four sample periods after the input that produced it was taken. The block moves the strobe into the system clock domain through a synchronizer. On each rising strobe it captures the 16-bit two's complement word and its out-of-range bit. It then presents the result as a valid/ready stream.

The block drives the converter's output-enable line from a local capture request. It ignores the bus while that line is low, because the bus then floats. The words that follow a new enable, or the end of a calibration, still hold stale pipeline contents, so the block drops them. A free-running strobe counter labels every emitted word with the index of the sample period that produced it. Out-of-range words can be clamped to full scale. The block counts out-of-range words that it delivers. A word that arrives while the consumer is stalled is lost, and a sticky flag records the loss.

Top module: `adc_capture`

## Requirements
- R1: After reset, out_valid, overflow, adc_oe and ovr_count are all zero.
- R2: adc_oe equals the value capture_en had one system clock earlier.
- R3: A rising edge of adc_dav captures adc_data and adc_ovr, and they reach out_data and out_ovr with out_valid high. While out_valid is high and out_ready is low, out_valid stays high and out_data and out_tag do not change.
- R4: A strobe that is detected while adc_oe is low produces no output word.
- R5: After adc_oe rises, the first LATENCY strobes (default 4) that arrive with adc_oe high produce no output word.
- R6: A strobe that arrives while adc_cal_done is low is dropped. After adc_cal_done rises, the next LATENCY strobes that arrive with adc_oe high are also dropped.
- R7: out_tag equals the zero-based index of the strobe that produced the word, minus LATENCY, modulo 2^16. Every strobe detected since reset is counted, whether it is dropped or delivered.
- R8: With SAT_EN set (the default), a word whose out-of-range bit is set leaves as 16'h7FFF if its bit 15 is 0, or as 16'h8000 if bit 15 is 1, with out_sat high. Any other word leaves unchanged with out_sat low.
- R9: A word that arrives while out_valid is high and out_ready is low is dropped, and the word already held is kept. overflow then stays high until reset.
- R10: ovr_count counts delivered words whose out-of-range bit is set, and it holds at its maximum value of 2^OVR_CNT_W-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| capture_en | input | 1 | Request to enable the converter's output drivers |
| adc_oe | output | 1 | Output-enable line to the converter |
| adc_dav | input | 1 | Data-valid strobe from the converter (asynchronous) |
| adc_data | input | 16 | Two's complement data bus from the converter |
| adc_ovr | input | 1 | Out-of-range bit from the converter |
| adc_cal_done | input | 1 | High when calibration is complete (asynchronous) |
| out_ready | input | 1 | Consumer accepts the word held on the output |
| out_valid | output | 1 | An output word is held |
| out_data | output | 16 | Output sample, clamped if saturation is on |
| out_ovr | output | 1 | Out-of-range bit of the output sample |
| out_sat | output | 1 | Output sample was clamped to full scale |
| out_tag | output | 16 | Sample period index of the output word |
| overflow | output | 1 | Sticky flag: a word was lost to back-pressure |
| ovr_count | output | OVR_CNT_W | Saturating count of delivered out-of-range words |

## Verification
The assertions check several rules on every cycle. adc_oe must track capture_en with a one-cycle delay. A held word must stay unchanged under back-pressure. The overflow flag must never clear. A clamped output may take only one of the two full-scale codes, and ovr_count must never fall. No word may appear while the enable is low. Some behaviour needs the scenarios in the bench to show it: the number of words dropped after an enable or after the end of a calibration, the value of each sample tag, the choice of clamp polarity, and which word survives when a second word arrives during a stall. The bench predicts each of these from its own strobe count.

// File: rtl/adc_cap_pkg.sv
package adc_cap_pkg;
  localparam int unsigned ADC_W = 16;
  localparam int unsigned TAG_W = 16;

  typedef struct packed {
    logic [TAG_W-1:0] tag;
    logic             ovr;
    logic [ADC_W-1:0] data;
  } cap_word_t;
endpackage

// File: rtl/adc_cap_sync.sv
module adc_cap_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_nxt;

  always_comb begin
    sh_nxt = {sh_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_nxt;
  end

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/adc_cap_gate.sv
module adc_cap_gate
  import adc_cap_pkg::*;
#(
  parameter int unsigned LATENCY = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dav_s,
  input  logic             cal_s,
  input  logic             oe,
  input  logic             oe_rise,
  input  logic [ADC_W-1:0] data,
  input  logic             ovr,
  output logic             word_vld,
  output cap_word_t        word
);
  localparam int unsigned FLUSH_W = $clog2(LATENCY + 1);
  localparam logic [FLUSH_W-1:0] FLUSH_LOAD = FLUSH_W'(LATENCY);
  localparam logic [TAG_W-1:0]   TAG_OFS    = TAG_W'(LATENCY);

  logic               dav_d_q, cal_d_q;
  logic [FLUSH_W-1:0] flush_q, flush_nxt;
  logic [TAG_W-1:0]   samp_q, samp_nxt;
  logic               strobe, cal_rise, live, restart;

  assign strobe   = dav_s & ~dav_d_q;
  assign cal_rise = cal_s & ~cal_d_q;
  assign restart  = oe_rise | cal_rise;
  assign live     = strobe & oe & cal_s & ~restart;

  always_comb begin
    samp_nxt  = samp_q;
    flush_nxt = flush_q;
    if (strobe) samp_nxt = samp_q + 1'b1;
    if (restart)
      flush_nxt = FLUSH_LOAD;
    else if (live && flush_q != '0)
      flush_nxt = flush_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dav_d_q <= 1'b0;
      cal_d_q <= 1'b0;
      flush_q <= FLUSH_LOAD;
      samp_q  <= '0;
    end else begin
      dav_d_q <= dav_s;
      cal_d_q <= cal_s;
      flush_q <= flush_nxt;
      samp_q  <= samp_nxt;
    end
  end

  assign word_vld  = live & (flush_q == '0);
  assign word.tag  = samp_q - TAG_OFS;
  assign word.ovr  = ovr;
  assign word.data = data;
endmodule

// File: rtl/adc_cap_outreg.sv
module adc_cap_outreg
  import adc_cap_pkg::*;
#(
  parameter bit          SAT_EN    = 1'b1,
  parameter int unsigned OVR_CNT_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 word_vld,
  input  cap_word_t            word,
  input  logic                 out_ready,
  output logic                 out_valid,
  output logic [ADC_W-1:0]     out_data,
  output logic                 out_ovr,
  output logic                 out_sat,
  output logic [TAG_W-1:0]     out_tag,
  output logic                 overflow,
  output logic [OVR_CNT_W-1:0] ovr_count
);
  localparam logic [ADC_W-1:0] POS_FULL = {1'b0, {(ADC_W-1){1'b1}}};
  localparam logic [ADC_W-1:0] NEG_FULL = {1'b1, {(ADC_W-1){1'b0}}};

  logic [ADC_W-1:0]     sat_data;
  logic                 sat_flag;
  logic                 stall, load;
  logic                 valid_nxt, ovf_nxt;
  logic [OVR_CNT_W-1:0] cnt_nxt;

  if (SAT_EN) begin : g_clamp
    assign sat_flag = word.ovr;
    assign sat_data = !word.ovr          ? word.data :
                      word.data[ADC_W-1] ? NEG_FULL  : POS_FULL;
  end else begin : g_raw
    assign sat_flag = 1'b0;
    assign sat_data = word.data;
  end

  assign stall = out_valid & ~out_ready;
  assign load  = word_vld & ~stall;

  always_comb begin
    valid_nxt = out_valid;
    if (load)           valid_nxt = 1'b1;
    else if (out_ready) valid_nxt = 1'b0;
    ovf_nxt = overflow | (word_vld & stall);
    cnt_nxt = ovr_count;
    if (load && word.ovr && ovr_count != '1) cnt_nxt = ovr_count + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      overflow  <= 1'b0;
      ovr_count <= '0;
    end else begin
      out_valid <= valid_nxt;
      overflow  <= ovf_nxt;
      ovr_count <= cnt_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_data <= '0;
      out_ovr  <= 1'b0;
      out_sat  <= 1'b0;
      out_tag  <= '0;
    end else if (load) begin
      out_data <= sat_data;
      out_ovr  <= word.ovr;
      out_sat  <= sat_flag;
      out_tag  <= word.tag;
    end
  end
endmodule

// File: rtl/adc_capture.sv
module adc_capture
  import adc_cap_pkg::*;
#(
  parameter int unsigned LATENCY     = 4,
  parameter int unsigned SYNC_STAGES = 2,
  parameter bit          SAT_EN      = 1'b1,
  parameter int unsigned OVR_CNT_W   = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 capture_en,
  output logic                 adc_oe,
  input  logic                 adc_dav,
  input  logic [ADC_W-1:0]     adc_data,
  input  logic                 adc_ovr,
  input  logic                 adc_cal_done,
  input  logic                 out_ready,
  output logic                 out_valid,
  output logic [ADC_W-1:0]     out_data,
  output logic                 out_ovr,
  output logic                 out_sat,
  output logic [TAG_W-1:0]     out_tag,
  output logic                 overflow,
  output logic [OVR_CNT_W-1:0] ovr_count
);
  logic      dav_s, cal_s, oe_nxt, oe_rise, word_vld;
  cap_word_t word;

  adc_cap_sync #(.STAGES(SYNC_STAGES)) i_sync_dav (
    .clk(clk), .rst_n(rst_n), .d(adc_dav), .q(dav_s)
  );
  adc_cap_sync #(.STAGES(SYNC_STAGES)) i_sync_cal (
    .clk(clk), .rst_n(rst_n), .d(adc_cal_done), .q(cal_s)
  );

  assign oe_nxt  = capture_en;
  assign oe_rise = oe_nxt & ~adc_oe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) adc_oe <= 1'b0;
    else        adc_oe <= oe_nxt;
  end

  adc_cap_gate #(.LATENCY(LATENCY)) i_gate (
    .clk(clk), .rst_n(rst_n), .dav_s(dav_s), .cal_s(cal_s),
    .oe(adc_oe), .oe_rise(oe_rise), .data(adc_data), .ovr(adc_ovr),
    .word_vld(word_vld), .word(word)
  );

  adc_cap_outreg #(.SAT_EN(SAT_EN), .OVR_CNT_W(OVR_CNT_W)) i_out (
    .clk(clk), .rst_n(rst_n), .word_vld(word_vld), .word(word),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
    .out_ovr(out_ovr), .out_sat(out_sat), .out_tag(out_tag),
    .overflow(overflow), .ovr_count(ovr_count)
  );
endmodule

// File: rtl/adc_capture_chk.sv
module adc_capture_chk #(
  parameter bit          SAT_EN    = 1'b1,
  parameter int unsigned OVR_CNT_W = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 capture_en,
  input logic                 adc_oe,
  input logic                 out_ready,
  input logic                 out_valid,
  input logic [15:0]          out_data,
  input logic                 out_ovr,
  input logic                 out_sat,
  input logic [15:0]          out_tag,
  input logic                 overflow,
  input logic [OVR_CNT_W-1:0] ovr_count
);
  assert_oe_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> adc_oe == $past(capture_en));

  assert_hold_under_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_tag));

  assert_quiet_when_disabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !adc_oe && !out_valid |=> !out_valid);

  assert_clamp_codes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_sat |-> SAT_EN && out_ovr && (out_data == 16'h7FFF || out_data == 16'h8000));

  assert_sticky_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  assert_count_monotonic_R10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ovr_count >= $past(ovr_count));
endmodule

bind adc_capture adc_capture_chk #(.SAT_EN(SAT_EN), .OVR_CNT_W(OVR_CNT_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .capture_en(capture_en), .adc_oe(adc_oe),
  .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
  .out_ovr(out_ovr), .out_sat(out_sat), .out_tag(out_tag),
  .overflow(overflow), .ovr_count(ovr_count)
);

// File: tb/test_adc_capture.sv
module test_adc_capture;
  localparam int CW = 3;

  typedef struct packed {
    logic [15:0] data;
    logic        ovr;
    logic        sat;
    logic [15:0] tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          capture_en = 1'b0;
  logic          adc_dav = 1'b0;
  logic [15:0]   adc_data = '0;
  logic          adc_ovr = 1'b0;
  logic          adc_cal_done = 1'b1;
  logic          out_ready = 1'b1;
  logic          adc_oe, out_valid, out_ovr, out_sat, overflow;
  logic [15:0]   out_data, out_tag;
  logic [CW-1:0] ovr_count;

  int   n_checks = 0;
  int   n_fail = 0;
  int   strobe_idx = 0;
  int   flush_left = 4;
  int   exp_cnt = 0;
  bit   oe_model = 1'b0;
  bit   cal_model = 1'b1;
  exp_t sb[$];

  always #2 clk = ~clk;

  adc_capture #(.OVR_CNT_W(CW)) i_adc_capture (
    .clk(clk), .rst_n(rst_n), .capture_en(capture_en), .adc_oe(adc_oe),
    .adc_dav(adc_dav), .adc_data(adc_data), .adc_ovr(adc_ovr),
    .adc_cal_done(adc_cal_done), .out_ready(out_ready), .out_valid(out_valid),
    .out_data(out_data), .out_ovr(out_ovr), .out_sat(out_sat), .out_tag(out_tag),
    .overflow(overflow), .ovr_count(ovr_count)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_sim();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  // Driver: predicts the outcome of one strobe, then drives it.
  task automatic send_word(input logic [15:0] d, input logic o, input bit lost);
    exp_t e;
    bit   emit;
    emit = 1'b0;
    if (oe_model && cal_model) begin
      if (flush_left > 0) flush_left--;
      else emit = 1'b1;
    end
    if (emit && !lost) begin
      e.ovr = o;
      e.sat = o;
      e.data = !o ? d : (d[15] ? 16'h8000 : 16'h7FFF);
      e.tag = 16'(strobe_idx - 4);
      sb.push_back(e);
      if (o && exp_cnt < 7) exp_cnt++;
    end
    strobe_idx++;
    @(posedge clk); #1;
    adc_data = d; adc_ovr = o; adc_dav = 1'b1;
    repeat (4) @(posedge clk);
    #1 adc_dav = 1'b0;
    repeat (4) @(posedge clk);
    #1;
  endtask

  // Monitor: compares each handshake against the scoreboard.
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (sb.size() == 0) begin
        n_checks++; n_fail++;
        $display("FAIL R3 R4 R5 R6: unexpected word actual %0h expected none", out_data);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check("R3 R8 data", 32'(out_data), 32'(e.data));
        check("R3 ovr", 32'(out_ovr), 32'(e.ovr));
        check("R8 sat", 32'(out_sat), 32'(e.sat));
        check("R7 tag", 32'(out_tag), 32'(e.tag));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_sim();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1 out_valid", 32'(out_valid), 0);
    check("R1 overflow", 32'(overflow), 0);
    check("R1 adc_oe", 32'(adc_oe), 0);
    check("R1 ovr_count", 32'(ovr_count), 0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk); #1;

    // R4: enable low, words ignored but counted
    send_word(16'hAAAA, 1'b0, 1'b0);
    check("R4 no output", 32'(out_valid), 0);
    send_word(16'h5555, 1'b1, 1'b0);
    check("R4 no output", 32'(out_valid), 0);

    // R2: enable
    capture_en = 1'b1; oe_model = 1'b1; flush_left = 4;
    @(posedge clk); #1;
    check("R2 adc_oe high", 32'(adc_oe), 1);
    repeat (2) @(posedge clk); #1;

    // R5: four stale words
    for (int i = 0; i < 4; i++) send_word(16'h1000 + 16'(i), 1'b0, 1'b0);
    check("R5 stale dropped", 32'(sb.size()), 0);

    // R3 R7 R8: main stream
    send_word(16'h1234, 1'b0, 1'b0);
    send_word(16'hFFFF, 1'b0, 1'b0);
    send_word(16'h8000, 1'b0, 1'b0);
    send_word(16'h7FFF, 1'b0, 1'b0);
    send_word(16'h0123, 1'b1, 1'b0);
    send_word(16'hF000, 1'b1, 1'b0);
    check("R10 ovr_count", 32'(ovr_count), 32'(exp_cnt));

    // R9: back-pressure
    out_ready = 1'b0;
    send_word(16'h0A0A, 1'b0, 1'b0);
    send_word(16'h0B0B, 1'b0, 1'b1);
    check("R9 overflow set", 32'(overflow), 1);
    check("R9 first word held", 32'(out_data), 32'h0A0A);
    out_ready = 1'b1;
    repeat (3) @(posedge clk); #1;
    check("R9 queue drained", 32'(sb.size()), 0);
    send_word(16'h0C0C, 1'b0, 1'b0);
    check("R9 overflow sticky", 32'(overflow), 1);

    // R2 R4 R5: disable, re-enable
    capture_en = 1'b0; oe_model = 1'b0;
    @(posedge clk); #1;
    check("R2 adc_oe low", 32'(adc_oe), 0);
    send_word(16'h2222, 1'b0, 1'b0);
    check("R4 no output", 32'(out_valid), 0);
    capture_en = 1'b1; oe_model = 1'b1; flush_left = 4;
    repeat (3) @(posedge clk); #1;
    for (int i = 0; i < 5; i++) send_word(16'h3000 + 16'(i), 1'b0, 1'b0);
    check("R5 only fifth word", 32'(sb.size()), 0);

    // R6: calibration
    adc_cal_done = 1'b0; cal_model = 1'b0;
    repeat (4) @(posedge clk); #1;
    send_word(16'h4444, 1'b0, 1'b0);
    check("R6 dropped during cal", 32'(out_valid), 0);
    adc_cal_done = 1'b1; cal_model = 1'b1; flush_left = 4;
    repeat (4) @(posedge clk); #1;
    for (int i = 0; i < 5; i++) send_word(16'h5000 + 16'(i), 1'b0, 1'b0);
    check("R6 flushed after cal", 32'(sb.size()), 0);

    // R10: saturating count
    for (int i = 0; i < 6; i++) send_word(16'h0100 + 16'(i), 1'b1, 1'b0);
    check("R10 ovr_count saturated", 32'(ovr_count), 32'(exp_cnt));
    check("R10 ovr_count max", 32'(ovr_count), 7);

    repeat (4) @(posedge clk); #1;
    check("R3 scoreboard empty", 32'(sb.size()), 0);
    finish_sim();
  end
endmodule